// File: doc/BRIEF.md
# Line Latch with Polarity Routing

This block sits between the sampling register of a column driver and its conversion stage. The sampling register collects one line of 6-bit gray codes. On the rising edge of a line strobe the block copies the whole line into a holding latch. It can complement every code on the way in. It also captures a polarity control, and from it gives every output a flag that selects either the upper or the lower reference bank. Neighbouring outputs always get opposite banks.

A drive-enable goes high on the falling edge of the strobe. Only the outputs that are active in the selected output-count mode receive it. The strobe is sampled by the block clock, and one strobe pulse is expected per line. The conversion stage reads the latched codes, the bank flags and the enables.

Top module: `line_latch_router`

## Requirements
- R1: The block captures `line_codes` into `lat_codes` at the first clock edge that samples `strb` high after a low sample. After that edge, `lat_codes` holds its value until the next such edge, even if `line_codes` changes while `strb` stays high.
- R2: If `inv_in` is 1 at that capture edge, every W-bit code (slot i occupies bits i*W to i*W+W-1) is stored bit-complemented. If `inv_in` is 0, the codes are stored unchanged.
- R3: If `pol_in` was 1 at the last capture, odd-numbered outputs (slot index 0, 2, 4...) have `bank_sel` 0, which selects the upper reference bank. Even-numbered outputs (index 1, 3...) have `bank_sel` 1, which selects the lower bank.
- R4: If `pol_in` was 0 at the last capture, the assignment of R3 is swapped: even slot indices have `bank_sel` 1 and odd slot indices have `bank_sel` 0. In both polarities, neighbouring outputs always have opposite flags.
- R5: Changes on `line_codes`, `pol_in`, `inv_in` or `narrow_sel` between captures have no effect on any output.
- R6: The edge that first samples `strb` low after a high sample sets the drive-enable of every active output. The capture edge clears all drive-enables.
- R7: After reset, `lat_codes` is 0 and every `drv_en` bit is 0. The enables stay 0 until the first falling strobe edge.
- R8: If `narrow_sel` was 1 at the last capture, only slots 0 to OUT_LO-1 are active. If it was 0, all NUM_OUT slots are active. Inactive slots keep `drv_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strb | input | 1 | Line strobe |
| line_codes | input | NUM_OUT*CODE_W | Gray codes from the sampling register, slot 0 in the low bits |
| pol_in | input | 1 | Polarity control, captured at the strobe rise |
| inv_in | input | 1 | Code inversion control, captured at the strobe rise |
| narrow_sel | input | 1 | 1 selects the reduced output count OUT_LO |
| lat_codes | output | NUM_OUT*CODE_W | Latched codes |
| bank_sel | output | NUM_OUT | Per-output bank flag: 0 = upper bank, 1 = lower bank |
| drv_en | output | NUM_OUT | Per-output drive-enable |

## Verification
The bench builds the block with NUM_OUT = 9, OUT_LO = 6 and CODE_W = 6. The odd output count gives an unpaired last slot. The reduced count leaves three inactive slots, so the cut-off of R8 can be seen on both sides. Each vector of the table captures a different code pattern, so inversion, both polarities and both count modes are checked across every slot. The bench also changes the data while the strobe is high to check that only one capture happens per pulse.

// File: rtl/lil_pkg.sv
package lil_pkg;
    // Bank flag encoding on bank_sel.
    localparam logic BANK_UPPER = 1'b0;
    localparam logic BANK_LOWER = 1'b1;
endpackage

// File: rtl/lil_strobe_edge.sv
module lil_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic strb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.strb = strb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = strb & ~st_q.strb;
    assign fall = ~strb & st_q.strb;
endmodule

// File: rtl/lil_code_latch.sv
module lil_code_latch #(
    parameter int NUM_OUT = 309,
    parameter int CODE_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap,
    input  logic                      pol_in,
    input  logic                      inv_in,
    input  logic                      narrow_in,
    input  logic [NUM_OUT*CODE_W-1:0] codes_in,
    output logic                      pol_q,
    output logic                      narrow_q,
    output logic [NUM_OUT*CODE_W-1:0] codes_q
);
    localparam int LINE_W = NUM_OUT * CODE_W;

    typedef struct packed {
        logic              pol;
        logic              narrow;
        logic [LINE_W-1:0] codes;
    } st_t;

    st_t st_d, st_q;
    logic [LINE_W-1:0] shaped;

    // Per-slot conditional complement.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
        assign shaped[i*CODE_W +: CODE_W] =
            inv_in ? ~codes_in[i*CODE_W +: CODE_W] : codes_in[i*CODE_W +: CODE_W];
    end

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.pol    = pol_in;
            st_d.narrow = narrow_in;
            st_d.codes  = shaped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_q    = st_q.pol;
    assign narrow_q = st_q.narrow;
    assign codes_q  = st_q.codes;

    // R1
    codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(codes_q));
    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(pol_q) && $stable(narrow_q)));
endmodule

// File: rtl/lil_drive_gate.sv
module lil_drive_gate #(
    parameter int NUM_OUT = 309,
    parameter int OUT_LO  = 300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic               fall,
    input  logic               narrow,
    output logic [NUM_OUT-1:0] drv_en
);
    typedef struct packed {
        logic en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise)      st_d.en = 1'b0;
        else if (fall) st_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_mask
        if (i < OUT_LO) begin : g_core
            assign drv_en[i] = st_q.en;
        end else begin : g_tail
            assign drv_en[i] = st_q.en & ~narrow;
        end
    end

    // R6
    en_clear_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (drv_en == '0));
    // R6
    en_set_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !rise) |=> drv_en[0]);
endmodule

// File: rtl/lil_bank_route.sv
module lil_bank_route #(
    parameter int NUM_OUT = 309
) (
    input  logic               pol,
    output logic [NUM_OUT-1:0] bank_sel
);
    import lil_pkg::*;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_route
        if (i % 2 == 0) begin : g_oddnum
            assign bank_sel[i] = pol ? BANK_UPPER : BANK_LOWER;
        end else begin : g_evennum
            assign bank_sel[i] = pol ? BANK_LOWER : BANK_UPPER;
        end
    end
endmodule

// File: rtl/line_latch_router.sv
module line_latch_router #(
    parameter int NUM_OUT = 309,
    parameter int OUT_LO  = 300,
    parameter int CODE_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strb,
    input  logic [NUM_OUT*CODE_W-1:0] line_codes,
    input  logic                      pol_in,
    input  logic                      inv_in,
    input  logic                      narrow_sel,
    output logic [NUM_OUT*CODE_W-1:0] lat_codes,
    output logic [NUM_OUT-1:0]        bank_sel,
    output logic [NUM_OUT-1:0]        drv_en
);
    logic rise, fall;
    logic pol_q, narrow_q;

    lil_strobe_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .strb (strb),
        .rise (rise),
        .fall (fall)
    );

    lil_code_latch #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (rise),
        .pol_in   (pol_in),
        .inv_in   (inv_in),
        .narrow_in(narrow_sel),
        .codes_in (line_codes),
        .pol_q    (pol_q),
        .narrow_q (narrow_q),
        .codes_q  (lat_codes)
    );

    lil_bank_route #(.NUM_OUT(NUM_OUT)) u_route (
        .pol     (pol_q),
        .bank_sel(bank_sel)
    );

    lil_drive_gate #(.NUM_OUT(NUM_OUT), .OUT_LO(OUT_LO)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .fall  (fall),
        .narrow(narrow_q),
        .drv_en(drv_en)
    );

    // R4
    bank_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel[0] != bank_sel[1]);
    // R8
    en_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(drv_en) == 0) || ($countones(drv_en) == OUT_LO)
        || ($countones(drv_en) == NUM_OUT));
endmodule

// File: tb/line_latch_router_bench.sv
module line_latch_router_bench;
    localparam int NO = 9;
    localparam int LO = 6;
    localparam int W  = 6;
    localparam int LW = NO * W;
    localparam logic [63:0] LMASK = (64'd1 << LW) - 64'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strb = 1'b0;
    logic [LW-1:0] line_codes = '0;
    logic pol_in = 1'b0, inv_in = 1'b0, narrow_sel = 1'b0;
    logic [LW-1:0] lat_codes;
    logic [NO-1:0] bank_sel, drv_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_latch_router #(.NUM_OUT(NO), .OUT_LO(LO), .CODE_W(W)) u_line_latch_router (
        .clk(clk), .rst_n(rst_n), .strb(strb), .line_codes(line_codes),
        .pol_in(pol_in), .inv_in(inv_in), .narrow_sel(narrow_sel),
        .lat_codes(lat_codes), .bank_sel(bank_sel), .drv_en(drv_en)
    );

    // Vector: {pol, inv, narrow, seed}
    localparam logic [10:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b0, 1'b0, 8'h15},
        {1'b1, 1'b1, 1'b0, 8'h2a},
        {1'b0, 1'b1, 1'b1, 8'h07},
        {1'b1, 1'b0, 1'b1, 8'h3f},
        {1'b0, 1'b1, 1'b0, 8'h91}
    };

    function automatic logic [63:0] mk_codes(input logic [7:0] seed);
        logic [63:0] r = '0;
        for (int i = 0; i < NO; i++) r[i*W +: W] = 6'((seed + i * 13) & 63);
        return r;
    endfunction

    function automatic logic [63:0] exp_bank(input logic pol);
        logic [63:0] r = '0;
        for (int i = 0; i < NO; i++) r[i] = (i % 2 == 1) ? pol : ~pol;
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_line(input logic pol, input logic inv, input logic nar, input logic [7:0] seed);
        logic [63:0] ec;
        ec = inv ? (~mk_codes(seed) & LMASK) : mk_codes(seed);
        @(negedge clk);
        line_codes = mk_codes(seed)[LW-1:0];
        pol_in = pol; inv_in = inv; narrow_sel = nar;
        strb = 1'b1;
        @(negedge clk);
        check("R2 codes after capture", 64'(lat_codes), ec);
        check("R6 enables low while strobe high", 64'(drv_en), 64'd0);
        // Disturb inputs while strobe still high: no second capture.
        line_codes = ~line_codes; pol_in = ~pol; inv_in = ~inv; narrow_sel = ~nar;
        @(negedge clk);
        strb = 1'b0;
        @(negedge clk);
        check("R1 single capture per pulse", 64'(lat_codes), ec);
        check(pol ? "R3 bank flags" : "R4 bank flags", 64'(bank_sel), exp_bank(pol));
        check("R8 R6 enables after fall", 64'(drv_en),
              nar ? ((64'd1 << LO) - 1) : ((64'd1 << NO) - 1));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] snap_c, snap_b, snap_e;
        repeat (3) @(negedge clk);
        check("R7 reset codes", 64'(lat_codes), 64'd0);
        check("R7 reset enables", 64'(drv_en), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 enables stay low before strobe", 64'(drv_en), 64'd0);

        for (int k = 0; k < 6; k++)
            run_line(VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:0]);

        // R5: no strobe, inputs wander.
        snap_c = 64'(lat_codes); snap_b = 64'(bank_sel); snap_e = 64'(drv_en);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            line_codes = mk_codes(8'(k * 29))[LW-1:0];
            pol_in = ~pol_in; inv_in = ~inv_in; narrow_sel = ~narrow_sel;
        end
        @(negedge clk);
        check("R5 codes unchanged", 64'(lat_codes), snap_c);
        check("R5 bank unchanged", 64'(bank_sel), snap_b);
        check("R5 enables unchanged", 64'(drv_en), snap_e);

        // R7: reset mid-run clears state.
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run reset codes", 64'(lat_codes), 64'd0);
        check("R7 mid-run reset enables", 64'(drv_en), 64'd0);
        rst_n = 1'b1;
        run_line(1'b1, 1'b0, 1'b1, 8'h3c);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule